// File: doc/BRIEF.md
# Programmable multi-threshold linear gate

The block forms one signed weighted sum of an N-bit binary input vector, using one programmable signed weight per input bit. That single sum is compared in parallel against a bank of programmable transition points. The output bit starts at a programmable base level and flips once for every transition point that the sum has reached. This gives a piecewise-constant function of the sum that can have several transitions.

With one transition point in use, the block is an ordinary linear threshold gate, and the transition point plays the part of the negated bias. With every weight set to one and a transition point at each integer, the block computes any symmetric function of its inputs, parity included.

A host programs the weights, the transition points and the base level through a simple register-write port. Data vectors arrive with a valid strobe. Each accepted vector produces one registered result bit, one cycle later.

Top module: `mtg_gate`

## Requirements
- R1: Weights are two's-complement signed values of W_BITS bits. The output for an accepted vector depends only on S, the sum of the weights whose input bit is 1.
- R2: The accumulator is ACC_W = W_BITS + clog2(N_IN+1) bits wide. It holds every sum from -N_IN*2^(W_BITS-1) to +N_IN*2^(W_BITS-1) without wrapping, and transition points at either extreme are compared exactly.
- R3: With base level 0 and only transition slot 0 in use (value P), the output is 1 exactly when S >= P, and 0 otherwise.
- R4: With base level 1 and ascending points t1<t2<t3 in slots 0..2, the output is 1 for S<t1, 0 for t1<=S<t2, 1 for t2<=S<t3, and 0 for S>=t3.
- R5: In general, the output equals the base level XOR the parity of the number of slots whose signed value is <= S. A slot holding the largest positive ACC_W value, 2^(ACC_W-1)-1, is never reached.
- R6: With every weight 1, base level 0 and slots holding 1..N_IN, the output equals the XOR of all input bits.
- R7: out_valid is 1 in exactly the cycle after a cycle with in_valid high, and out_bit carries that vector's result in the same cycle.
- R8: When in_valid is low, out_bit keeps its previous value in the next cycle.
- R9: A register write made in the same cycle as an accepted vector does not affect that vector's result. It does affect the next accepted vector.
- R10: After synchronous reset, out_valid and out_bit are 0, all weights and the base level are 0, and all slots hold the largest positive value.
- R11: The write address selects the storage: address i (0..N_IN-1) is weight i and takes cfg_wdata[W_BITS-1:0]; address N_IN+j is slot j and takes all ACC_W bits; address N_IN+T_MAX is the base level and takes cfg_wdata[0]. A write to any higher address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (5) | Register write address |
| cfg_wdata | input | ACC_W (10) | Register write data |
| in_valid | input | 1 | Input vector valid |
| in_data | input | N_IN (8) | Binary input vector |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_bit | output | 1 | Result bit |

## Verification
Some properties are checked on every cycle by assertions. These are the one-cycle valid latency and the hold of out_bit between inputs. Another is that the accumulator always stays inside the range set by the weight magnitudes. The last is that a base-level write lands in its register.

The function itself can only be shown by the bench's scenarios. That covers the threshold-gate case, the multi-transition interval pattern and parity under unit weights. The scenarios also cover sums at both extreme ends, the ordering of a write against a vector in the same cycle, writes to unused addresses, and the values left by reset.

// File: rtl/mtg_pkg.sv
package mtg_pkg;
   // accumulator width that holds +/- N * 2^(W-1) without wrap
   function automatic int acc_width(input int n_in, input int w_bits);
      return w_bits + $clog2(n_in + 1);
   endfunction

   function automatic int addr_width(input int n_in, input int t_max);
      return $clog2(n_in + t_max + 1);
   endfunction
endpackage

// File: rtl/mtg_cfg_regs.sv
module mtg_cfg_regs
   import mtg_pkg::*;
#(
   parameter int N_IN   = 8,
   parameter int W_BITS = 6,
   parameter int T_MAX  = 8,
   parameter int ACC_W  = acc_width(N_IN, W_BITS),
   parameter int ADDR_W = addr_width(N_IN, T_MAX)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cfg_we,
   input  logic [ADDR_W-1:0]         cfg_addr,
   input  logic [ACC_W-1:0]          cfg_wdata,
   output logic [N_IN*W_BITS-1:0]    w_flat,
   output logic [T_MAX*ACC_W-1:0]    t_flat,
   output logic                      base_q
);
   localparam int ADDR_BASE = N_IN + T_MAX;
   localparam logic [ACC_W-1:0] SLOT_TOP = {1'b0, {(ACC_W-1){1'b1}}};

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_wt
         always_ff @(posedge clk) begin
            if (rst)
               w_flat[i*W_BITS +: W_BITS] <= '0;
            else if (cfg_we && cfg_addr == ADDR_W'(i))
               w_flat[i*W_BITS +: W_BITS] <= cfg_wdata[W_BITS-1:0];
         end
      end
      for (genvar j = 0; j < T_MAX; j++) begin : g_slot
         always_ff @(posedge clk) begin
            if (rst)
               t_flat[j*ACC_W +: ACC_W] <= SLOT_TOP;
            else if (cfg_we && cfg_addr == ADDR_W'(N_IN + j))
               t_flat[j*ACC_W +: ACC_W] <= cfg_wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         base_q <= 1'b0;
      else if (cfg_we && cfg_addr == ADDR_W'(ADDR_BASE))
         base_q <= cfg_wdata[0];
   end

   // R11
   base_write_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_addr == ADDR_W'(ADDR_BASE)) |=> (base_q == $past(cfg_wdata[0])));
endmodule

// File: rtl/mtg_wsum.sv
module mtg_wsum
   import mtg_pkg::*;
#(
   parameter int N_IN   = 8,
   parameter int W_BITS = 6,
   parameter int ACC_W  = acc_width(N_IN, W_BITS)
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [N_IN-1:0]               x,
   input  logic [N_IN*W_BITS-1:0]        w_flat,
   output logic signed [ACC_W-1:0]       sum
);
   localparam int BOUND = N_IN * (1 << (W_BITS - 1));

   logic signed [ACC_W-1:0] term [N_IN];

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_term
         logic signed [W_BITS-1:0] wi;
         assign wi      = w_flat[i*W_BITS +: W_BITS];
         assign term[i] = x[i] ? ACC_W'(wi) : '0;
      end
   endgenerate

   always_comb begin
      sum = '0;
      for (int i = 0; i < N_IN; i++)
         sum = sum + term[i];
   end

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (sum >= -BOUND) && (sum <= BOUND));
endmodule

// File: rtl/mtg_thr_bank.sv
module mtg_thr_bank
   import mtg_pkg::*;
#(
   parameter int T_MAX = 8,
   parameter int ACC_W = 10
) (
   input  logic signed [ACC_W-1:0]   sum,
   input  logic [T_MAX*ACC_W-1:0]    t_flat,
   output logic                      cross_par
);
   logic [T_MAX-1:0] reached;

   generate
      for (genvar j = 0; j < T_MAX; j++) begin : g_cmp
         logic signed [ACC_W-1:0] tj;
         assign tj         = t_flat[j*ACC_W +: ACC_W];
         assign reached[j] = (sum >= tj);
      end
      if (T_MAX == 1) begin : g_one
         assign cross_par = reached[0];
      end else begin : g_many
         assign cross_par = ^reached;
      end
   endgenerate
endmodule

// File: rtl/mtg_gate.sv
module mtg_gate
   import mtg_pkg::*;
#(
   parameter int N_IN   = 8,
   parameter int W_BITS = 6,
   parameter int T_MAX  = 8,
   parameter int ACC_W  = acc_width(N_IN, W_BITS),
   parameter int ADDR_W = addr_width(N_IN, T_MAX)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [ACC_W-1:0]  cfg_wdata,
   input  logic              in_valid,
   input  logic [N_IN-1:0]   in_data,
   output logic              out_valid,
   output logic              out_bit
);
   generate
      if (N_IN < 1)   begin : g_bad_n  $error("N_IN must be at least 1"); end
      if (W_BITS < 2) begin : g_bad_w  $error("W_BITS must be at least 2"); end
      if (T_MAX < 1)  begin : g_bad_t  $error("T_MAX must be at least 1"); end
      if (ACC_W < acc_width(N_IN, W_BITS)) begin : g_bad_acc
         $error("ACC_W too narrow for the weight range");
      end
   endgenerate

   logic [N_IN*W_BITS-1:0]  w_flat;
   logic [T_MAX*ACC_W-1:0]  t_flat;
   logic                    base_q;
   logic signed [ACC_W-1:0] sum;
   logic                    cross_par;

   mtg_cfg_regs #(
      .N_IN(N_IN), .W_BITS(W_BITS), .T_MAX(T_MAX), .ACC_W(ACC_W), .ADDR_W(ADDR_W)
   ) u_cfg (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .w_flat(w_flat), .t_flat(t_flat), .base_q(base_q)
   );

   mtg_wsum #(
      .N_IN(N_IN), .W_BITS(W_BITS), .ACC_W(ACC_W)
   ) u_sum (
      .clk(clk), .rst(rst), .x(in_data), .w_flat(w_flat), .sum(sum)
   );

   mtg_thr_bank #(
      .T_MAX(T_MAX), .ACC_W(ACC_W)
   ) u_thr (
      .sum(sum), .t_flat(t_flat), .cross_par(cross_par)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_bit   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_bit <= base_q ^ cross_par;
      end
   end

   // R7
   valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   // R7
   valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   // R8
   bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_bit));
endmodule

// File: tb/sim_mtg_gate.sv
module sim_mtg_gate;
   localparam int N  = 8;
   localparam int WB = 6;
   localparam int T  = 8;
   localparam int AC = 10;
   localparam int AW = 5;
   localparam int A_BASE = N + T;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [AC-1:0] cfg_wdata = '0;
   logic          in_valid = 1'b0;
   logic [N-1:0]  in_data = '0;
   logic          out_valid;
   logic          out_bit;

   always #10 clk = ~clk;   // 50 MHz

   mtg_gate u0 (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_bit(out_bit)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   int    w_m [N];
   int    t_m [T];
   bit    base_m = 1'b0;
   bit    last_bit = 1'b0;
   bit    exp_q [$];
   string tag_q [$];
   bit    mon_on = 1'b1;

   function automatic int sx(input int d, input int bits);
      int v;
      v = d & ((1 << bits) - 1);
      if (v >= (1 << (bits - 1))) v = v - (1 << bits);
      return v;
   endfunction

   function automatic bit model(input logic [N-1:0] x);
      int s;
      int c;
      s = 0;
      c = 0;
      for (int i = 0; i < N; i++) if (x[i]) s += w_m[i];
      for (int j = 0; j < T; j++) if (t_m[j] <= s) c++;
      return base_m ^ c[0];
   endfunction

   task automatic model_wr(input int a, input int d);
      if (a < N)          w_m[a] = sx(d, WB);
      else if (a < N + T) t_m[a-N] = sx(d, AC);
      else if (a == A_BASE) base_m = d[0];
   endtask

   task automatic check(input bit got, input bit exp, input string req);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = AC'(d);
      @(negedge clk);
      cfg_we = 1'b0;
      model_wr(a, d);
   endtask

   task automatic apply(input logic [N-1:0] x, input string req);
      @(negedge clk);
      in_valid = 1'b1; in_data = x;
      exp_q.push_back(model(x)); tag_q.push_back(req);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic apply_wr(input logic [N-1:0] x, input int a, input int d, input string req);
      @(negedge clk);
      in_valid = 1'b1; in_data = x;
      cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = AC'(d);
      exp_q.push_back(model(x)); tag_q.push_back(req);
      model_wr(a, d);
      @(negedge clk);
      in_valid = 1'b0; cfg_we = 1'b0;
   endtask

   // monitor: pops one expected item for each result
   always @(negedge clk) begin
      if (!rst && mon_on && out_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R7: got unexpected out_valid=1 expected 0");
         end else begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            last_bit = e;
            check(out_bit, e, t);
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) w_m[i] = 0;
      for (int j = 0; j < T; j++) t_m[j] = (1 << (AC - 1)) - 1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R10 reset state at the ports
      check(out_valid, 1'b0, "R10");
      check(out_bit, 1'b0, "R10");
      apply(8'hFF, "R10");
      apply(8'h00, "R10");

      // R3 single threshold gate, mixed signed weights (R1)
      begin
         int wv [N] = '{3, -2, 5, -4, 1, 2, -1, 7};
         for (int i = 0; i < N; i++) wr(i, wv[i]);
      end
      wr(N + 0, 3);
      apply(8'h01, "R3");      // 3 -> 1
      apply(8'h02, "R3");      // -2 -> 0
      apply(8'h03, "R3");      // 1 -> 0
      apply(8'h05, "R3");      // 8 -> 1
      apply(8'h0A, "R1");
      apply(8'hA5, "R1");
      apply(8'h5A, "R1");
      apply(8'hC3, "R1");

      // R4 / R5 multi-transition interval pattern
      wr(A_BASE, 1);
      wr(N + 0, -2);
      wr(N + 1, 1);
      wr(N + 2, 4);
      apply(8'h0A, "R4");      // -6 -> 1
      apply(8'h02, "R4");      // -2 -> 0
      apply(8'h03, "R4");      // 1 -> 1
      apply(8'h01, "R4");      // 3 -> 1
      apply(8'h11, "R4");      // 4 -> 0
      apply(8'hFF, "R5");      // 11 -> 0
      apply(8'h30, "R5");
      apply(8'h4C, "R5");

      // R11 writes above the map change nothing
      wr(20, 10'h3FF);
      wr(31, 10'h155);
      apply(8'h01, "R11");
      apply(8'h0A, "R11");
      // R11 base level takes only bit 0
      wr(A_BASE, 2);
      apply(8'h01, "R11");

      // R9 write in the same cycle as an accepted vector
      apply_wr(8'h01, N + 1, 100, "R9");
      apply(8'h01, "R9");
      apply_wr(8'h05, 0, -30, "R9");
      apply(8'h05, "R9");

      // R7 latency, R8 hold
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h01;
      exp_q.push_back(model(8'h01)); tag_q.push_back("R7");
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid, 1'b1, "R7");
      @(negedge clk);
      check(out_valid, 1'b0, "R7");
      repeat (3) @(negedge clk);
      check(out_bit, last_bit, "R8");
      check(out_valid, 1'b0, "R8");

      // R2 extremes of the sum range
      wr(A_BASE, 0);
      for (int j = 0; j < T; j++) wr(N + j, (1 << (AC - 1)) - 1);
      for (int i = 0; i < N; i++) wr(i, -32);
      wr(N + 0, -256);
      apply(8'hFF, "R2");      // -256 >= -256 -> 1
      wr(N + 0, -255);
      apply(8'hFF, "R2");      // -> 0
      for (int i = 0; i < N; i++) wr(i, 31);
      wr(N + 0, 248);
      apply(8'hFF, "R2");      // 248 -> 1
      apply(8'h7F, "R2");      // 217 -> 0
      wr(N + 0, 249);
      apply(8'hFF, "R2");      // -> 0

      // R6 parity with unit weights
      for (int i = 0; i < N; i++) wr(i, 1);
      for (int j = 0; j < T; j++) wr(N + j, j + 1);
      begin
         logic [N-1:0] pv [6] = '{8'h00, 8'h01, 8'h03, 8'h07, 8'hB6, 8'hFF};
         for (int k = 0; k < 6; k++) begin
            apply(pv[k], "R6");
            check(model(pv[k]), ^pv[k], "R6");
         end
      end

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_chk++; n_bad++;
         $display("FAIL R7: got %0d results missing expected 0", exp_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule